// File: doc/BRIEF.md
# Multi-Mode 24-bit Counter Core

This core holds a 24-bit count that moves one step per up or down pulse. A six-bit control word chooses the digit arithmetic: plain binary, six packed BCD digits, or a time-of-day format of hours, minutes and seconds held as BCD pairs. The same word chooses how the count behaves at its ends. In normal mode it wraps around. In non-recycle mode it stops after the first wrap. In divide-by-N mode an underflow reloads the preset value. Strobes load the count from a 24-bit preset or clear it. Clearing also sets a sign flag. The sign flag follows the direction of the last overflow.

Each wrap produces a one-cycle carry or borrow pulse and flips a matching toggle output. A comparator watches for the count equal to the preset, and a toggle records each new match. Two output pins present these events in one of three mappings set by the control word. The core sits behind a register interface and an input front end. Both of those are outside this block. The front end supplies clean single-cycle pulses.

The run state machine has two states. ST_RUN accepts count pulses. ST_HALT ignores them. The transition ST_RUN to ST_HALT is taken on a wrap while non-recycle mode is active. The transition ST_HALT to ST_RUN is taken on a load or clear strobe. Every other case stays in the current state.

Top module: `cnt24_core`

## Requirements
- R1: Reset and the clear strobe `clear_cnt` set the count to 0 and `sign` to 1. A clear wins over a load and over a count pulse in the same cycle.
- R2: The load strobe `load_pre` copies `preset` into the count on the next edge, in any state. It leaves `sign` unchanged.
- R3: Binary mode (`cfg[3]`=0, `cfg[0]`=0) counts modulo 2^24. An up step from 0xFFFFFF gives 0, a one-cycle carry pulse and `sign`=1. A down step from 0 gives 0xFFFFFF, a one-cycle borrow pulse and `sign`=0.
- R4: BCD mode (`cfg[0]`=1, `cfg[3]`=0) steps six decimal digits, with the least significant digit in bits 3:0. The maximum is 0x999999. Up from 0x999999 gives 0 with carry. Down from 0 gives 0x999999 with borrow.
- R5: Clock mode (`cfg[3]`=1, any `cfg[0]`) counts seconds in bits 7:0, minutes in bits 15:8 and hours in bits 23:16. Seconds and minutes run 00 to 59. The maximum is 0x235959, and wrapping works as in R4.
- R6: Non-recycle mode (`cfg[1]`=1, `cfg[2]`=0) halts after the first carry or borrow. Further count pulses leave the count unchanged until a load or clear.
- R7: Divide-by-N mode (`cfg[2]`=1) reloads `preset` and pulses borrow on a down step from 0. Up steps wrap as in normal mode.
- R8: Pin map `cfg[5:4]`=00 drives `cy_pin`/`bw_pin` with the inverted carry/borrow pulses. Map 01 (and 10) drives them with the direct pulses.
- R9: Pin map `cfg[5:4]`=11 drives `cy_pin` low while the count equals `preset`. It drives `bw_pin` with a comparator toggle that flips one cycle after each edge that turns the match on. Reset clears the toggle.
- R10: `cy_tgl` flips with every carry pulse and `bw_tgl` with every borrow pulse. Both reset to 0.
- R11: An up and a down pulse in the same cycle cause no step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg | input | 6 | Count/output control word |
| preset | input | 24 | Preset and compare value |
| cnt_up | input | 1 | Up-count pulse |
| cnt_dn | input | 1 | Down-count pulse |
| load_pre | input | 1 | Load count from preset |
| clear_cnt | input | 1 | Clear count, set sign |
| count | output | 24 | Current count |
| sign | output | 1 | Sign flag |
| cy_pin | output | 1 | Mapped carry-side output |
| bw_pin | output | 1 | Mapped borrow-side output |
| cy_tgl | output | 1 | Carry toggle |
| bw_tgl | output | 1 | Borrow toggle |

## Verification
The properties assume that reset is asserted before any clocked activity. They also assume that `preset` and the control word are sampled at the same edge as the strobes they accompany. In the decimal modes, the digit checks hold only while the count holds legal digits. The bench therefore always loads a legal value before counting in BCD or clock mode. It changes `cfg` and `preset` only at the falling edge that also applies the next pulse pattern, so each value is stable across the edge that uses it.

// File: rtl/cnt24_pkg.sv
package cnt24_pkg;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HALT = 1'b1
    } run_state_e;

    typedef enum logic [1:0] {
        AR_BIN   = 2'd0,
        AR_BCD   = 2'd1,
        AR_CLOCK = 2'd2
    } arith_e;

    // control word bit positions
    localparam int CFG_BCD   = 0;
    localparam int CFG_NOREC = 1;
    localparam int CFG_DIVN  = 2;
    localparam int CFG_CLOCK = 3;

    localparam logic [1:0] MAP_INV    = 2'b00;
    localparam logic [1:0] MAP_DIRECT = 2'b01;
    localparam logic [1:0] MAP_CMP    = 2'b11;

    // highest digit value before a digit carries, clock format
    function automatic logic [3:0] clock_digit_limit(input int pos);
        if (pos == 1 || pos == 3)
            return 4'd5;
        else if (pos == 5)
            return 4'd2;
        else
            return 4'd9;
    endfunction

    // digit value of the clock-format maximum (23:59:59)
    function automatic logic [3:0] clock_digit_max(input int pos);
        if (pos == 4)
            return 4'd3;
        return clock_digit_limit(pos);
    endfunction

endpackage

// File: rtl/cnt24_arith.sv
module cnt24_arith
    import cnt24_pkg::*;
#(
    parameter int W = 24
) (
    input  logic [W-1:0] val,
    input  arith_e       mode,
    output logic [W-1:0] inc_val,
    output logic [W-1:0] dec_val,
    output logic [W-1:0] max_val,
    output logic         at_max,
    output logic         at_zero
);

    localparam int ND = W / 4;

    logic [ND-1:0] cy_ch;
    logic [ND-1:0] bw_ch;
    logic [W-1:0]  dinc;
    logic [W-1:0]  ddec;
    logic [W-1:0]  dmax;

    assign cy_ch[0] = 1'b1;
    assign bw_ch[0] = 1'b1;

    for (genvar g = 0; g < ND; g++) begin : g_digit
        logic [3:0] d;
        logic [3:0] lim;
        logic [3:0] top;

        assign d   = val[4*g +: 4];
        assign lim = (mode == AR_CLOCK) ? clock_digit_limit(g) : 4'd9;
        assign top = (mode == AR_CLOCK) ? clock_digit_max(g)   : 4'd9;

        assign dinc[4*g +: 4] = !cy_ch[g] ? d : ((d >= lim) ? 4'd0 : d + 4'd1);
        assign ddec[4*g +: 4] = !bw_ch[g] ? d : ((d == 4'd0) ? lim : d - 4'd1);
        assign dmax[4*g +: 4] = top;

        if (g < ND - 1) begin : g_link
            assign cy_ch[g+1] = cy_ch[g] & (d >= lim);
            assign bw_ch[g+1] = bw_ch[g] & (d == 4'd0);
        end
    end

    always_comb begin
        if (mode == AR_BIN) begin
            inc_val = val + 1'b1;
            dec_val = val - 1'b1;
            max_val = '1;
        end else begin
            inc_val = dinc;
            dec_val = ddec;
            max_val = dmax;
        end
        at_max  = (val == max_val);
        at_zero = (val == '0);
    end

endmodule

// File: rtl/cnt24_outmap.sv
module cnt24_outmap
    import cnt24_pkg::*;
(
    input  logic [1:0] map_sel,
    input  logic       carry_p,
    input  logic       borrow_p,
    input  logic       cmp_eq,
    input  logic       cmp_tgl,
    output logic       pin_cy,
    output logic       pin_bw
);

    always_comb begin
        unique case (map_sel)
            MAP_INV: begin
                pin_cy = ~carry_p;
                pin_bw = ~borrow_p;
            end
            MAP_CMP: begin
                pin_cy = ~cmp_eq;
                pin_bw = cmp_tgl;
            end
            default: begin
                pin_cy = carry_p;
                pin_bw = borrow_p;
            end
        endcase
    end

endmodule

// File: rtl/cnt24_core.sv
module cnt24_core
    import cnt24_pkg::*;
#(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [5:0]   cfg,
    input  logic [W-1:0] preset,
    input  logic         cnt_up,
    input  logic         cnt_dn,
    input  logic         load_pre,
    input  logic         clear_cnt,
    output logic [W-1:0] count,
    output logic         sign,
    output logic         cy_pin,
    output logic         bw_pin,
    output logic         cy_tgl,
    output logic         bw_tgl
);

    run_state_e   st_q, st_nx;
    arith_e       ar_mode;

    logic [W-1:0] count_q, cnt_nx;
    logic [W-1:0] inc_val, dec_val, max_val;
    logic         at_max, at_zero;
    logic         sign_q, carry_q, borrow_q;
    logic         cy_tgl_q, bw_tgl_q;
    logic         eq_prev_q, cmp_tgl_q, cmp_eq;
    logic         step_up, step_dn, divn, norec;
    logic         ev_carry, ev_borrow;

    // mode decode: clock format overrides the BCD bit
    always_comb begin
        if (cfg[CFG_CLOCK])
            ar_mode = AR_CLOCK;
        else if (cfg[CFG_BCD])
            ar_mode = AR_BCD;
        else
            ar_mode = AR_BIN;
    end

    assign divn    = cfg[CFG_DIVN];
    assign norec   = cfg[CFG_NOREC] & ~divn;
    assign step_up = cnt_up & ~cnt_dn;
    assign step_dn = cnt_dn & ~cnt_up;
    assign cmp_eq  = (count_q == preset);

    cnt24_arith #(.W(W)) u_arith (
        .val     (count_q),
        .mode    (ar_mode),
        .inc_val (inc_val),
        .dec_val (dec_val),
        .max_val (max_val),
        .at_max  (at_max),
        .at_zero (at_zero)
    );

    // next count and wrap events; clear beats load beats counting
    always_comb begin
        cnt_nx    = count_q;
        ev_carry  = 1'b0;
        ev_borrow = 1'b0;
        if (clear_cnt) begin
            cnt_nx = '0;
        end else if (load_pre) begin
            cnt_nx = preset;
        end else if (st_q == ST_RUN && step_up) begin
            if (at_max) begin
                cnt_nx   = '0;
                ev_carry = 1'b1;
            end else begin
                cnt_nx = inc_val;
            end
        end else if (st_q == ST_RUN && step_dn) begin
            if (at_zero) begin
                cnt_nx    = divn ? preset : max_val;
                ev_borrow = 1'b1;
            end else begin
                cnt_nx = dec_val;
            end
        end
    end

    // run/halt transitions
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            ST_RUN:  if ((ev_carry || ev_borrow) && norec) st_nx = ST_HALT;
            ST_HALT: if (clear_cnt || load_pre)            st_nx = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= ST_RUN;
        else
            st_q <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q   <= '0;
            sign_q    <= 1'b1;
            carry_q   <= 1'b0;
            borrow_q  <= 1'b0;
            cy_tgl_q  <= 1'b0;
            bw_tgl_q  <= 1'b0;
            eq_prev_q <= 1'b0;
            cmp_tgl_q <= 1'b0;
        end else begin
            count_q   <= cnt_nx;
            carry_q   <= ev_carry;
            borrow_q  <= ev_borrow;
            eq_prev_q <= cmp_eq;
            if (clear_cnt || ev_carry)
                sign_q <= 1'b1;
            else if (ev_borrow)
                sign_q <= 1'b0;
            if (ev_carry)
                cy_tgl_q <= ~cy_tgl_q;
            if (ev_borrow)
                bw_tgl_q <= ~bw_tgl_q;
            if (cmp_eq && !eq_prev_q)
                cmp_tgl_q <= ~cmp_tgl_q;
        end
    end

    cnt24_outmap u_outmap (
        .map_sel  (cfg[5:4]),
        .carry_p  (carry_q),
        .borrow_p (borrow_q),
        .cmp_eq   (cmp_eq),
        .cmp_tgl  (cmp_tgl_q),
        .pin_cy   (cy_pin),
        .pin_bw   (bw_pin)
    );

    assign count  = count_q;
    assign sign   = sign_q;
    assign cy_tgl = cy_tgl_q;
    assign bw_tgl = bw_tgl_q;

endmodule

// File: rtl/cnt24_checks.sv
module cnt24_checks
    import cnt24_pkg::*;
#(
    parameter int W = 24
) (
    input logic         clk,
    input logic         rst_n,
    input run_state_e   st,
    input logic [W-1:0] count,
    input logic [W-1:0] preset,
    input logic         sign,
    input logic         carry_q,
    input logic         borrow_q,
    input logic         cy_tgl,
    input logic         bw_tgl,
    input logic         load_pre,
    input logic         clear_cnt,
    input logic         cnt_up,
    input logic         cnt_dn
);

    a_r1_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clear_cnt |=> (count == '0) && sign);

    a_r2_load_preset: assert property (@(posedge clk) disable iff (!rst_n)
        load_pre && !clear_cnt |=> count == $past(preset));

    a_r3_carry_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        carry_q |-> (count == '0) && sign);

    a_r3_borrow_sign: assert property (@(posedge clk) disable iff (!rst_n)
        borrow_q |-> !sign);

    a_r6_halt_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HALT) && !load_pre && !clear_cnt |=> $stable(count));

    a_r10_carry_flips: assert property (@(posedge clk) disable iff (!rst_n)
        carry_q |-> cy_tgl != $past(cy_tgl));

    a_r10_borrow_flips: assert property (@(posedge clk) disable iff (!rst_n)
        borrow_q |-> bw_tgl != $past(bw_tgl));

    a_r11_both_still: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_up && cnt_dn && !load_pre && !clear_cnt |=> $stable(count));

endmodule

bind cnt24_core cnt24_checks #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .st        (st_q),
    .count     (count_q),
    .preset    (preset),
    .sign      (sign_q),
    .carry_q   (carry_q),
    .borrow_q  (borrow_q),
    .cy_tgl    (cy_tgl_q),
    .bw_tgl    (bw_tgl_q),
    .load_pre  (load_pre),
    .clear_cnt (clear_cnt),
    .cnt_up    (cnt_up),
    .cnt_dn    (cnt_dn)
);

// File: tb/cnt24_core_tb.sv
module cnt24_core_tb;

    localparam int W = 24;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [5:0]   cfg, cfg_nx;
    logic [W-1:0] preset, pre_nx;
    logic         up, dn, ld, clr;
    logic [W-1:0] count;
    logic         sign, cy_pin, bw_pin, cy_tgl, bw_tgl;

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         sgn;
        logic         cyp;
        logic         bwp;
        logic         ct;
        logic         bt;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    checks = 0;
    int    errors = 0;
    logic  m_ct = 1'b0;
    logic  m_bt = 1'b0;

    always #10 clk = ~clk;

    cnt24_core #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg(cfg), .preset(preset),
        .cnt_up(up), .cnt_dn(dn), .load_pre(ld), .clear_cnt(clr),
        .count(count), .sign(sign), .cy_pin(cy_pin), .bw_pin(bw_pin),
        .cy_tgl(cy_tgl), .bw_tgl(bw_tgl)
    );

    // driver: one pulse pattern per call; ea/eb are carry/borrow events,
    // or the literal pin levels when the comparator map (11) is active
    task automatic step(input logic u, input logic d, input logic l, input logic c,
                        input logic [W-1:0] ecnt, input logic esgn,
                        input logic ea, input logic eb, input string tag);
        exp_t e;
        @(negedge clk);
        cfg = cfg_nx; preset = pre_nx;
        up = u; dn = d; ld = l; clr = c;
        e.cnt = ecnt;
        e.sgn = esgn;
        if (cfg[5:4] == 2'b11) begin
            e.cyp = ea;
            e.bwp = eb;
        end else begin
            if (ea) m_ct = ~m_ct;
            if (eb) m_bt = ~m_bt;
            e.cyp = (cfg[5:4] == 2'b00) ? ~ea : ea;
            e.bwp = (cfg[5:4] == 2'b00) ? ~eb : eb;
        end
        e.ct = m_ct;
        e.bt = m_bt;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    // monitor: compares one item per clock after the edge
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (exp_q.size() > 0) begin
                exp_t  e;
                exp_t  a;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                a = {count, sign, cy_pin, bw_pin, cy_tgl, bw_tgl};
                checks++;
                if (a !== e) begin
                    errors++;
                    $display("FAIL %s actual cnt=%h sgn=%b cy=%b bw=%b ct=%b bt=%b expected cnt=%h sgn=%b cy=%b bw=%b ct=%b bt=%b",
                             t, a.cnt, a.sgn, a.cyp, a.bwp, a.ct, a.bt,
                             e.cnt, e.sgn, e.cyp, e.bwp, e.ct, e.bt);
                end
            end
        end
    end

    task automatic do_reset(input string tag);
        logic ecy, ebw;
        @(negedge clk);
        rst_n = 1'b0;
        up = 0; dn = 0; ld = 0; clr = 0;
        cfg = cfg_nx; preset = pre_nx;
        @(negedge clk);
        @(negedge clk);
        if (cfg[5:4] == 2'b00)      begin ecy = 1'b1; ebw = 1'b1; end
        else if (cfg[5:4] == 2'b11) begin ecy = (preset != '0); ebw = 1'b0; end
        else                        begin ecy = 1'b0; ebw = 1'b0; end
        checks++;
        if (count !== '0 || sign !== 1'b1 || cy_tgl !== 1'b0 || bw_tgl !== 1'b0 ||
            cy_pin !== ecy || bw_pin !== ebw) begin
            errors++;
            $display("FAIL %s actual cnt=%h sgn=%b ct=%b bt=%b cy=%b bw=%b expected cnt=0 sgn=1 ct=0 bt=0 cy=%b bw=%b",
                     tag, count, sign, cy_tgl, bw_tgl, cy_pin, bw_pin, ecy, ebw);
        end
        rst_n = 1'b1;
        m_ct = 1'b0;
        m_bt = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        up = 0; dn = 0; ld = 0; clr = 0;
        cfg_nx = 6'b010000; pre_nx = 24'hFFFFFE;
        cfg = cfg_nx; preset = pre_nx;
        do_reset("R1 reset state");

        // binary, direct pins
        step(0,0,1,0, 24'hFFFFFE, 1, 0,0, "R2 load preset");
        step(1,0,0,0, 24'hFFFFFF, 1, 0,0, "R3 up step");
        step(1,0,0,0, 24'h000000, 1, 1,0, "R3 R10 up wrap carry");
        step(1,1,0,0, 24'h000000, 1, 0,0, "R11 both pulses");
        step(0,1,0,0, 24'hFFFFFF, 0, 0,1, "R3 R10 down wrap borrow");
        step(0,1,0,0, 24'hFFFFFE, 0, 0,0, "R3 down step");
        step(1,0,1,1, 24'h000000, 1, 0,0, "R1 clear priority");

        // inverted pin map
        cfg_nx = 6'b000000;
        step(0,0,0,0, 24'h000000, 1, 0,0, "R8 inverted idle");
        step(0,1,0,0, 24'hFFFFFF, 0, 0,1, "R8 inverted borrow");
        step(0,0,0,0, 24'hFFFFFF, 0, 0,0, "R8 inverted pulse ends");

        // BCD
        cfg_nx = 6'b010001; pre_nx = 24'h000009;
        step(0,0,1,0, 24'h000009, 0, 0,0, "R4 load");
        step(1,0,0,0, 24'h000010, 0, 0,0, "R4 digit carry");
        pre_nx = 24'h999999;
        step(0,0,1,0, 24'h999999, 0, 0,0, "R4 load max");
        step(1,0,0,0, 24'h000000, 1, 1,0, "R4 up wrap");
        step(0,1,0,0, 24'h999999, 0, 0,1, "R4 down wrap");

        // clock format, BCD bit also set
        cfg_nx = 6'b011001; pre_nx = 24'h235959;
        step(0,0,1,0, 24'h235959, 0, 0,0, "R5 load max");
        step(1,0,0,0, 24'h000000, 1, 1,0, "R5 up wrap");
        pre_nx = 24'h005959;
        step(0,0,1,0, 24'h005959, 1, 0,0, "R5 load");
        step(1,0,0,0, 24'h010000, 1, 0,0, "R5 minute/hour carry");
        step(0,1,0,0, 24'h005959, 1, 0,0, "R5 borrow through digits");
        step(0,0,0,1, 24'h000000, 1, 0,0, "R1 clear");
        step(0,1,0,0, 24'h235959, 0, 0,1, "R5 down wrap");
        pre_nx = 24'h200000;
        step(0,0,1,0, 24'h200000, 0, 0,0, "R5 load");
        step(0,1,0,0, 24'h195959, 0, 0,0, "R5 hour tens borrow");

        // non-recycle
        cfg_nx = 6'b010010; pre_nx = 24'hFFFFFF;
        step(0,0,1,0, 24'hFFFFFF, 0, 0,0, "R6 load");
        step(1,0,0,0, 24'h000000, 1, 1,0, "R6 first carry");
        step(1,0,0,0, 24'h000000, 1, 0,0, "R6 halted up");
        step(0,1,0,0, 24'h000000, 1, 0,0, "R6 halted down");
        step(0,0,1,0, 24'hFFFFFF, 1, 0,0, "R6 load resumes");
        step(1,0,0,0, 24'h000000, 1, 1,0, "R6 carry again");
        step(0,0,0,1, 24'h000000, 1, 0,0, "R6 clear resumes");
        step(1,0,0,0, 24'h000001, 1, 0,0, "R6 counting after clear");

        // divide-by-N
        cfg_nx = 6'b010100; pre_nx = 24'h000002;
        step(0,0,1,0, 24'h000002, 1, 0,0, "R7 load");
        step(0,1,0,0, 24'h000001, 1, 0,0, "R7 down");
        step(0,1,0,0, 24'h000000, 1, 0,0, "R7 down to zero");
        step(0,1,0,0, 24'h000002, 0, 0,1, "R7 reload preset");
        step(0,1,0,0, 24'h000001, 0, 0,0, "R7 down after reload");
        step(1,0,0,0, 24'h000002, 0, 0,0, "R7 up step");

        // comparator map after a fresh reset
        cfg_nx = 6'b110000; pre_nx = 24'h000003;
        do_reset("R9 R1 reset in comparator map");
        step(0,0,0,0, 24'h000000, 1, 1,0, "R9 no match");
        step(1,0,0,0, 24'h000001, 1, 1,0, "R9 no match");
        step(1,0,0,0, 24'h000002, 1, 1,0, "R9 no match");
        step(1,0,0,0, 24'h000003, 1, 0,0, "R9 match pin low");
        step(0,0,0,0, 24'h000003, 1, 0,1, "R9 toggle flips");
        step(1,0,0,0, 24'h000004, 1, 1,1, "R9 match ends");
        step(0,1,0,0, 24'h000003, 1, 0,1, "R9 new match");
        step(0,0,0,0, 24'h000003, 1, 0,0, "R9 toggle flips back");

        @(negedge clk);
        up = 0; dn = 0; ld = 0; clr = 0;
        wait (exp_q.size() == 0);
        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule